// File: doc/BRIEF.md
# PLL Clock Control Register Unit

This block is the software-visible control register of a clock controller that serves two phase-locked loops: a system PLL and a processor (MCU) PLL. Software writes and reads one 32-bit word over a plain register bus in the bus clock domain. The stored fields drive the clock controller's control outputs: two restart requests, the two PLL enables, the 16 MHz reference source select, the oscillator enable, the system PLL input select, the MCU prescaler select and a 4-bit bus clock divider code.

The two restart bits clear themselves after a handshake with a slow 32 kHz clock. That clock is brought into the bus domain through a synchroniser, and its rising edges act as timing ticks. Turning the system PLL off is delayed by a down-counter loaded from a shutdown count input, and the count steps once per slow tick. Turning the MCU PLL off takes effect at once. Each enable is forced on by its own hardware enable input and by reset. A status port shows the real enable outputs, and the register itself reads back the enable bits as software last wrote them.

Top module: `pllc_ctrl_reg`

## Requirements
- R1: After reset the register reads 0x00000003. Both PLL enable outputs are 1, both restart outputs are 0, and every configuration output is 0.
- R2: Writing 1 to bit 22 (system restart) or to bit 21 (MCU restart) sets that bit and its restart output on the next bus clock. The bit clears itself at the second slow-clock tick that follows. A tick is a rising edge of the slow clock seen through a two-stage synchroniser, so the bit stays set for one to two slow periods.
- R3: Writing 0 to a restart bit has no effect. Writing 1 to a restart bit that is still set is ignored and does not lengthen the request.
- R4: Writing 0 to bit 1 clears the read-back bit 1 at once and loads the shutdown counter from `sd_count`. The system PLL enable output stays 1 until `sd_count`+1 slow ticks have passed, and then drops to 0.
- R5: Writing 1 to bit 1 during a pending countdown cancels it, and the system PLL enable output stays 1.
- R6: Writing 0 to bit 0 drops the MCU PLL enable output and the read-back bit 0 on the next bus clock. Writing 1 raises both again.
- R7: While `spll_hw_en` or `mpll_hw_en` is high, the matching enable bit and output are forced to 1 on the next clock. This overrides a software write of 0 in the same cycle and cancels any pending countdown.
- R8: Bits 18 (16 MHz source: 1 = radio reference), 17 (oscillator enable), 16 (system PLL input: 1 = external high-frequency input), 15 (prescaler: 1 = divide by 2) and 13:10 (bus clock divider code n, giving divide by n+1) are stored on a write. They read back as written and drive their outputs on the next clock.
- R9: Bits 31:23, 20:19, 14 and 9:2 always read 0, and writes to them are ignored.
- R10: `pll_status` bit 1 equals the system PLL enable output and bit 0 equals the MCU PLL enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_slow | input | 1 | 32 kHz slow clock, sampled asynchronously |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always valid) |
| sd_count | input | 8 | Shutdown tick count for the system PLL |
| spll_hw_en | input | 1 | Hardware force-on for the system PLL |
| mpll_hw_en | input | 1 | Hardware force-on for the MCU PLL |
| spll_restart | output | 1 | System PLL restart request |
| mpll_restart | output | 1 | MCU PLL restart request |
| spll_enable | output | 1 | System PLL enable |
| mpll_enable | output | 1 | MCU PLL enable |
| ref16_sel | output | 1 | 16 MHz source select |
| osc_enable | output | 1 | Oscillator circuit enable |
| spll_src_sel | output | 1 | System PLL input select |
| mpu_prescale | output | 1 | MCU PLL prescaler select |
| bclk_div_code | output | 4 | Bus clock divider code |
| pll_status | output | 2 | Actual enables {system, MCU} |

## Verification
Register fields, the MCU enable and the hardware overrides all change on the first bus clock after the stimulus. A slow-clock rising edge becomes a tick three bus clocks after it is sampled: two synchroniser flops plus the edge register. So the clearing of a restart bit and each countdown step land a fixed number of clocks after a slow edge. The bench changes inputs only on falling edges. One nanosecond after every rising edge it advances a behavioural model from the inputs just sampled, including its own history of slow-clock samples, and compares every output and the read word against it. This pins each result to the exact cycle it is due, not just to a window.

// File: rtl/pllc_pkg.sv
package pllc_pkg;
   localparam int unsigned P_SRST    = 22;
   localparam int unsigned P_MRST    = 21;
   localparam int unsigned P_REFSEL  = 18;
   localparam int unsigned P_OSCEN   = 17;
   localparam int unsigned P_SRCSEL  = 16;
   localparam int unsigned P_PRESC   = 15;
   localparam int unsigned P_DIV_LO  = 10;
   localparam int unsigned P_SPEN    = 1;
   localparam int unsigned P_MPEN    = 0;
   localparam int unsigned N_RESTART = 2;
   localparam int unsigned P_DIV_LIM = 14;

   typedef struct packed {
      logic ref_sel;
      logic osc_en;
      logic src_sel;
      logic presc;
   } pllc_cfg_t;
endpackage

// File: rtl/pllc_slow_tick.sv
module pllc_slow_tick #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_clk,
   output logic tick
);
   localparam int unsigned MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [MSB:0] sync_q;
   logic         last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[MSB-1:0], slow_clk};
         last_q <= sync_q[MSB];
      end
   end

   assign tick = sync_q[MSB] & ~last_q;

   // R2: a tick is a single bus-clock pulse
   a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pllc_restart_bit.sv
module pllc_restart_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic set_req,
   output logic busy
);
   logic busy_q;
   logic seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         seen_q <= 1'b0;
      end else if (busy_q) begin
         if (tick) begin
            busy_q <= ~seen_q;
            seen_q <= ~seen_q;
         end
      end else if (set_req) begin
         busy_q <= 1'b1;
         seen_q <= 1'b0;
      end
   end

   assign busy = busy_q;

   a_r2_clear_second_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && seen_q && tick) |=> !busy_q);
   a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !tick) |=> busy_q);
   a_r2_set_on_request: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && set_req) |=> busy_q);
endmodule

// File: rtl/pllc_sys_enable.sv
module pllc_sys_enable #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             hw_en,
   input  logic             wr_one,
   input  logic             wr_zero,
   input  logic [CNT_W-1:0] load_val,
   output logic             sw_bit,
   output logic             pll_on
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   logic             sw_q, on_q, pend_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q   <= 1'b1;
         on_q   <= 1'b1;
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (hw_en || wr_one) begin
         sw_q   <= 1'b1;
         on_q   <= 1'b1;
         pend_q <= 1'b0;
      end else if (wr_zero) begin
         sw_q <= 1'b0;
         if (on_q) begin
            pend_q <= 1'b1;
            cnt_q  <= load_val;
         end
      end else if (pend_q && tick) begin
         if (cnt_q == '0) begin
            on_q   <= 1'b0;
            pend_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign sw_bit = sw_q;
   assign pll_on = on_q;

   a_r4_hold_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && cnt_q != '0) |=> pll_on);
   a_r4_off_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (pll_on && !(pend_q && tick && cnt_q == '0)) |=> pll_on);
   a_r5_rewrite_cancels: assert property (@(posedge clk) disable iff (!rst_n)
      wr_one |=> (pll_on && !pend_q));
   a_r7_hw_forces_on: assert property (@(posedge clk) disable iff (!rst_n)
      hw_en |=> (pll_on && sw_bit));
endmodule

// File: rtl/pllc_ctrl_reg.sv
module pllc_ctrl_reg
   import pllc_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned DIV_W       = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_slow,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [CNT_W-1:0]  sd_count,
   input  logic              spll_hw_en,
   input  logic              mpll_hw_en,
   output logic              spll_restart,
   output logic              mpll_restart,
   output logic              spll_enable,
   output logic              mpll_enable,
   output logic              ref16_sel,
   output logic              osc_enable,
   output logic              spll_src_sel,
   output logic              mpu_prescale,
   output logic [DIV_W-1:0]  bclk_div_code,
   output logic [1:0]        pll_status
);
   localparam int unsigned DIV_HI = P_DIV_LO + DIV_W - 1;

   if (DATA_W < P_SRST + 1) begin : g_bad_width
      $error("DATA_W too narrow for the field layout");
   end
   if (DIV_HI >= P_DIV_LIM) begin : g_bad_div
      $error("DIV_W overlaps the prescaler field");
   end

   logic                 tick;
   logic [N_RESTART-1:0] rst_busy;
   pllc_cfg_t            cfg_q;
   logic [DIV_W-1:0]     div_q;
   logic                 mp_sw_q, mp_on_q, sp_sw;

   pllc_slow_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk(clk), .rst_n(rst_n), .slow_clk(clk_slow), .tick(tick)
   );

   for (genvar i = 0; i < N_RESTART; i++) begin : g_restart
      localparam int unsigned BIT = (i == 0) ? P_SRST : P_MRST;
      pllc_restart_bit u_bit (
         .clk(clk), .rst_n(rst_n), .tick(tick),
         .set_req(bus_wr && bus_wdata[BIT]), .busy(rst_busy[i])
      );
   end

   pllc_sys_enable #(.CNT_W(CNT_W)) u_sys (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hw_en(spll_hw_en),
      .wr_one(bus_wr && bus_wdata[P_SPEN]),
      .wr_zero(bus_wr && !bus_wdata[P_SPEN]),
      .load_val(sd_count), .sw_bit(sp_sw), .pll_on(spll_enable)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         div_q <= '0;
      end else if (bus_wr) begin
         cfg_q.ref_sel <= bus_wdata[P_REFSEL];
         cfg_q.osc_en  <= bus_wdata[P_OSCEN];
         cfg_q.src_sel <= bus_wdata[P_SRCSEL];
         cfg_q.presc   <= bus_wdata[P_PRESC];
         div_q         <= bus_wdata[DIV_HI:P_DIV_LO];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mp_sw_q <= 1'b1;
         mp_on_q <= 1'b1;
      end else if (mpll_hw_en) begin
         mp_sw_q <= 1'b1;
         mp_on_q <= 1'b1;
      end else if (bus_wr) begin
         mp_sw_q <= bus_wdata[P_MPEN];
         mp_on_q <= bus_wdata[P_MPEN];
      end
   end

   always_comb begin
      bus_rdata                  = '0;
      bus_rdata[P_SRST]          = rst_busy[0];
      bus_rdata[P_MRST]          = rst_busy[1];
      bus_rdata[P_REFSEL]        = cfg_q.ref_sel;
      bus_rdata[P_OSCEN]         = cfg_q.osc_en;
      bus_rdata[P_SRCSEL]        = cfg_q.src_sel;
      bus_rdata[P_PRESC]         = cfg_q.presc;
      bus_rdata[DIV_HI:P_DIV_LO] = div_q;
      bus_rdata[P_SPEN]          = sp_sw;
      bus_rdata[P_MPEN]          = mp_sw_q;
   end

   assign spll_restart  = rst_busy[0];
   assign mpll_restart  = rst_busy[1];
   assign mpll_enable   = mp_on_q;
   assign ref16_sel     = cfg_q.ref_sel;
   assign osc_enable    = cfg_q.osc_en;
   assign spll_src_sel  = cfg_q.src_sel;
   assign mpu_prescale  = cfg_q.presc;
   assign bclk_div_code = div_q;
   assign pll_status    = {spll_enable, mpll_enable};

   a_r6_mcu_off_next: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !bus_wdata[P_MPEN] && !mpll_hw_en) |=> (!mpll_enable && !bus_rdata[P_MPEN]));
   a_r7_mcu_hw_on: assert property (@(posedge clk) disable iff (!rst_n)
      mpll_hw_en |=> mpll_enable);
   a_r8_div_stored: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr |=> (bclk_div_code == $past(bus_wdata[DIV_HI:P_DIV_LO])));
   a_r8_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(bclk_div_code));
endmodule

// File: tb/pllc_ctrl_reg_tb.sv
`timescale 1ns/1ps
module pllc_ctrl_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clk_slow = 1'b0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  sd_count = '0;
   logic        spll_hw_en = 1'b0, mpll_hw_en = 1'b0;
   logic        spll_restart, mpll_restart, spll_enable, mpll_enable;
   logic        ref16_sel, osc_enable, spll_src_sel, mpu_prescale;
   logic [3:0]  bclk_div_code;
   logic [1:0]  pll_status;

   int n_chk = 0, n_bad = 0, cyc = 0;
   string phase = "R1 reset";

   pllc_ctrl_reg u_dut (
      .clk(clk), .rst_n(rst_n), .clk_slow(clk_slow), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sd_count(sd_count),
      .spll_hw_en(spll_hw_en), .mpll_hw_en(mpll_hw_en),
      .spll_restart(spll_restart), .mpll_restart(mpll_restart),
      .spll_enable(spll_enable), .mpll_enable(mpll_enable),
      .ref16_sel(ref16_sel), .osc_enable(osc_enable), .spll_src_sel(spll_src_sel),
      .mpu_prescale(mpu_prescale), .bclk_div_code(bclk_div_code), .pll_status(pll_status)
   );

   always #4 clk = ~clk;

   // slow clock: 16 bus periods, changed on falling edges
   int slow_div = 0;
   always @(negedge clk) begin
      slow_div <= (slow_div == 7) ? 0 : slow_div + 1;
      if (slow_div == 7) clk_slow <= ~clk_slow;
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s (%s) cycle %0d: actual %h expected %h", tag, phase, cyc, act, exp);
      end
   endtask

   // behavioural reference model
   int   hist[$];
   bit   m_req[2];
   int   m_ticks[2];
   bit   m_ssw, m_son, m_msw, m_mon, m_pend;
   int   m_cnt;
   bit   m_ref, m_osc, m_src, m_pre;
   int   m_div;

   function automatic logic [31:0] model_word();
      logic [31:0] w = '0;
      w[22] = m_req[0]; w[21] = m_req[1];
      w[18] = m_ref; w[17] = m_osc; w[16] = m_src; w[15] = m_pre;
      w[13:10] = m_div[3:0];
      w[1] = m_ssw; w[0] = m_msw;
      return w;
   endfunction

   always @(posedge clk) begin
      bit tk;
      #1;
      cyc++;
      if (!rst_n) begin
         hist = '{0, 0, 0, 0};
         m_req = '{0, 0}; m_ticks = '{0, 0};
         m_ssw = 1; m_son = 1; m_msw = 1; m_mon = 1; m_pend = 0; m_cnt = 0;
         m_ref = 0; m_osc = 0; m_src = 0; m_pre = 0; m_div = 0;
      end else begin
         hist.push_front(int'(clk_slow));
         void'(hist.pop_back());
         tk = (hist[2] == 1) && (hist[3] == 0);
         for (int i = 0; i < 2; i++) begin
            if (m_req[i]) begin
               if (tk) m_ticks[i]++;
               if (m_ticks[i] == 2) m_req[i] = 0;
            end else if (bus_wr && bus_wdata[22 - i]) begin
               m_req[i] = 1; m_ticks[i] = 0;
            end
         end
         if (mpll_hw_en) begin m_msw = 1; m_mon = 1; end
         else if (bus_wr) begin m_msw = bus_wdata[0]; m_mon = bus_wdata[0]; end
         if (spll_hw_en || (bus_wr && bus_wdata[1])) begin
            m_ssw = 1; m_son = 1; m_pend = 0;
         end else if (bus_wr) begin
            m_ssw = 0;
            if (m_son) begin m_pend = 1; m_cnt = sd_count; end
         end else if (m_pend && tk) begin
            if (m_cnt == 0) begin m_son = 0; m_pend = 0; end
            else m_cnt--;
         end
         if (bus_wr) begin
            m_ref = bus_wdata[18]; m_osc = bus_wdata[17];
            m_src = bus_wdata[16]; m_pre = bus_wdata[15];
            m_div = bus_wdata[13:10];
         end
      end
      check("R8", bus_rdata, model_word());
      check("R9", bus_rdata & 32'hFF98_43FC, 32'h0);
      check("R2", {30'b0, spll_restart, mpll_restart}, {30'b0, m_req[0], m_req[1]});
      check("R4", {31'b0, spll_enable}, {31'b0, m_son});
      check("R6", {31'b0, mpll_enable}, {31'b0, m_mon});
      check("R8", {24'b0, ref16_sel, osc_enable, spll_src_sel, mpu_prescale, bclk_div_code},
            {24'b0, m_ref, m_osc, m_src, m_pre, m_div[3:0]});
      check("R10", {30'b0, pll_status}, {30'b0, m_son, m_mon});
   end

   task automatic wr(logic [31:0] v);
      @(negedge clk); bus_wr = 1'b1; bus_wdata = v;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset value at the ports
      check("R1", bus_rdata, 32'h0000_0003);
      check("R1", {28'b0, spll_enable, mpll_enable, spll_restart, mpll_restart}, 32'hC);
      idle(3);

      phase = "R8 R9 fields";
      wr(32'hFF9F_FFFF & ~32'h0060_0000);
      idle(3);
      wr(32'h0001_1403);
      idle(3);
      wr(32'h0000_8003);
      idle(3);

      phase = "R2 restart";
      wr(32'h0040_0003);
      idle(40);
      wr(32'h0020_0003);
      idle(40);

      phase = "R3 ignored writes";
      wr(32'h0000_0003);
      wr(32'h0060_0003);
      idle(5);
      wr(32'h0060_0003);
      idle(12);
      wr(32'h0040_0003);
      idle(40);

      phase = "R4 countdown";
      sd_count = 8'd3;
      wr(32'h0000_0001);
      idle(100);
      sd_count = 8'd0;
      wr(32'h0000_0003);
      wr(32'h0000_0001);
      idle(40);

      phase = "R5 cancel";
      wr(32'h0000_0003);
      sd_count = 8'd5;
      wr(32'h0000_0001);
      idle(30);
      wr(32'h0000_0003);
      idle(120);

      phase = "R6 mcu off";
      wr(32'h0000_0002);
      idle(3);
      wr(32'h0000_0003);
      idle(3);

      phase = "R7 hardware enables";
      sd_count = 8'd2;
      wr(32'h0000_0000);
      idle(10);
      @(negedge clk); mpll_hw_en = 1'b1;
      @(negedge clk); mpll_hw_en = 1'b0;
      idle(70);
      @(negedge clk); spll_hw_en = 1'b1;
      @(negedge clk); spll_hw_en = 1'b0;
      idle(5);
      @(negedge clk); spll_hw_en = 1'b1; mpll_hw_en = 1'b1;
      bus_wr = 1'b1; bus_wdata = 32'h0;
      @(negedge clk); bus_wr = 1'b0; spll_hw_en = 1'b0; mpll_hw_en = 1'b0;
      idle(60);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog (%s): actual running expected finished", phase);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule